// File: doc/BRIEF.md
# Nibble-Serial Handshake Transmitter

This block shifts a short value out one bit at a time over a single shared wire. The receiving side paces the transfer. Before each bit the transmitter waits until the wire is seen released high. It then drives the bit's level for a fixed number of clock cycles and drives the wire high again. A one-cycle strobe marks the moment the bit is placed on the wire. A second strobe marks the moment the wire is returned high. A transfer is four bits, most significant first. In wide mode the upper nibble is sent and then the lower one, back to back, for eight bits in total.

The sampled wire level is asynchronous to the block's clock, so it passes through a two-flop synchronizer. After every release, and after a start, the wait test is blanked for as many cycles as the synchronizer is deep. This keeps a level the transmitter drove itself from being mistaken for the receiver's release. The start strobe is the block's only flow control. A start is taken only while `busy` is low, and no request is queued. A caller that sees `busy` high must present its start again once `done` has pulsed. Nothing here models the receiver or the party that pulls the wire low between bits.

Top module: `nhtx_top`

## Requirements
- R1: A `tx_start` pulse while `busy` is low is accepted, and `busy` is high in the cycle after the accepting edge.
- R2: A `tx_start` pulse while `busy` is high has no effect: the bits in flight are unchanged and no extra bits follow.
- R3: With `tx_byte` low, exactly 4 bits are sent, taken from `tx_data[3:0]`.
- R4: Bits leave most significant first.
- R5: A bit is driven only after the synchronized wire level is seen high. When the wire is released after a low period, the bit strobe appears in the cycle after the third rising clock edge at which `line_in` is high.
- R6: A 0 bit drives `line_out` low and a 1 bit drives it high. The level is held from the drive strobe until the return strobe.
- R7: `line_out` is high at every time outside a bit's hold period, including after each bit and after the end of a transfer.
- R8: `bit_stb` is a one-cycle pulse at the drive and at the return of every bit. The two pulses of a bit are exactly HOLD_CYC cycles apart (HOLD_CYC is a parameter with default 4 and must be at least 2).
- R9: With `tx_byte` high, 8 bits are sent: `tx_data[7:4]` first, then `tx_data[3:0]`.
- R10: `done` is high for exactly one cycle, the cycle after the last bit's return strobe, and `busy` falls at the same edge.
- R11: Out of reset, `line_out` is high and `bit_stb`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | NIB_W*NIBS (8) | Value to send, captured at the accepting edge |
| tx_start | input | 1 | Start request, honoured only while idle |
| tx_byte | input | 1 | 1 sends all nibbles, upper first; 0 sends only the low nibble |
| line_in | input | 1 | Sampled level of the shared wire |
| line_out | output | 1 | Drive value for the shared wire |
| bit_stb | output | 1 | One-cycle pulse at bit drive and at bit return |
| busy | output | 1 | High from acceptance until the end of the transfer |
| done | output | 1 | One-cycle pulse at the end of the transfer |

## Verification
The bound checker watches several properties on every cycle. A start is accepted when the block is idle. A bit is never driven unless the synchronized level was high at the driving edge. The wire sits high outside a bit's hold period. Strobes and `done` are single-cycle pulses, `done` follows a return strobe, and `busy` falls only with `done`. Other behaviour can only be seen through the bench's scenarios, with a receiver that holds the wire low for varying times: the bit values and their order, the exact three-edge latency after release, the strobe spacing, the bit count in each mode, and the fact that a start arriving mid-transfer changes nothing.

// File: rtl/nhtx_pkg.sv
package nhtx_pkg;
  // Controller phases: idle, waiting for the wire, holding a bit, closing.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2,
    ST_FIN  = 2'd3
  } nhtx_state_e;
endpackage

// File: rtl/nhtx_sync.sv
module nhtx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nhtx_hold_timer.sv
module nhtx_hold_timer #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt;

  // After a load of L, expire is seen at the (L+1)-th following edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/nhtx_shifter.sv
module nhtx_shifter #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NIB_W*NIBS-1:0] din,
  input  logic                  wide,
  input  logic                  shift,
  output logic                  msb,
  output logic                  last_bit
);
  localparam int DW  = NIB_W * NIBS;
  localparam int BCW = $clog2(NIB_W + 1);
  localparam int NCW = $clog2(NIBS + 1);

  logic [DW-1:0]  sh;
  logic [BCW-1:0] bits_left;
  logic [NCW-1:0] nibs_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bits_left <= '0;
      nibs_left <= '0;
    end else if (load) begin
      // Narrow mode moves the low nibble to the top so the MSB tap is shared.
      sh        <= wide ? din : (din << (DW - NIB_W));
      bits_left <= BCW'(NIB_W);
      nibs_left <= wide ? NCW'(NIBS) : NCW'(1);
    end else if (shift) begin
      sh <= sh << 1;
      if (bits_left == BCW'(1)) begin
        bits_left <= BCW'(NIB_W);
        nibs_left <= nibs_left - 1'b1;
      end else begin
        bits_left <= bits_left - 1'b1;
      end
    end
  end

  assign msb      = sh[DW-1];
  assign last_bit = (bits_left == BCW'(1)) && (nibs_left == NCW'(1));
endmodule

// File: rtl/nhtx_ctrl.sv
module nhtx_ctrl
  import nhtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        line_hi,
  input  logic        tmr_expire,
  input  logic        last_bit,
  input  logic        bit_val,
  output logic        ld_data,
  output logic        tmr_load,
  output logic        shift_en,
  output logic        line_drv,
  output logic        bit_stb,
  output logic        busy,
  output logic        done,
  output nhtx_state_e st_q
);
  logic go_drive;
  logic go_release;

  assign go_drive   = (st_q == ST_WAIT) && tmr_expire && line_hi;
  assign go_release = (st_q == ST_HOLD) && tmr_expire;
  assign ld_data    = (st_q == ST_IDLE) && start;
  assign shift_en   = go_release;
  // Timer is reloaded on acceptance (blanking), on drive (hold) and on
  // every release that is followed by another bit (blanking).
  assign tmr_load   = ld_data || go_drive || (go_release && !last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      line_drv <= 1'b1;
      bit_stb  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      done    <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q <= ST_WAIT;
            busy <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (go_drive) begin
            line_drv <= bit_val;
            bit_stb  <= 1'b1;
            st_q     <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (go_release) begin
            line_drv <= 1'b1;
            bit_stb  <= 1'b1;
            st_q     <= last_bit ? ST_FIN : ST_WAIT;
          end
        end
        ST_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nhtx_top.sv
module nhtx_top
  import nhtx_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int NIBS        = 2,
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NIB_W*NIBS-1:0] tx_data,
  input  logic                  tx_start,
  input  logic                  tx_byte,
  input  logic                  line_in,
  output logic                  line_out,
  output logic                  bit_stb,
  output logic                  busy,
  output logic                  done
);
  localparam int MAXV = (HOLD_CYC > SYNC_STAGES) ? HOLD_CYC : SYNC_STAGES;
  localparam int TW   = $clog2(MAXV + 1);

  logic          line_s;
  logic          tmr_expire;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          ld_data;
  logic          shift_en;
  logic          msb;
  logic          last_bit;
  nhtx_state_e   st;

  nhtx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  // A load in the wait phase starts a bit hold; any other load is blanking.
  assign tmr_val = (st == ST_WAIT) ? TW'(HOLD_CYC - 1) : TW'(SYNC_STAGES);

  nhtx_hold_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expire(tmr_expire)
  );

  nhtx_shifter #(.NIB_W(NIB_W), .NIBS(NIBS)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(ld_data), .din(tx_data),
    .wide(tx_byte), .shift(shift_en), .msb(msb), .last_bit(last_bit)
  );

  nhtx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .line_hi(line_s),
    .tmr_expire(tmr_expire), .last_bit(last_bit), .bit_val(msb),
    .ld_data(ld_data), .tmr_load(tmr_load), .shift_en(shift_en),
    .line_drv(line_out), .bit_stb(bit_stb), .busy(busy), .done(done),
    .st_q(st)
  );
endmodule

// File: rtl/nhtx_chk.sv
module nhtx_chk
  import nhtx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        tx_start,
  input logic        line_out,
  input logic        bit_stb,
  input logic        busy,
  input logic        done,
  input logic        line_s,
  input nhtx_state_e st
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_start) |=> busy);

  p_wait_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && bit_stb) |-> $past(line_s));

  p_line_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_HOLD) |-> line_out);

  p_stb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bit_stb) && !busy));

  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind nhtx_top nhtx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .line_out(line_out),
  .bit_stb(bit_stb), .busy(busy), .done(done), .line_s(line_s), .st(st)
);

// File: tb/sim_nhtx_top.sv
`timescale 1ns/1ps
module sim_nhtx_top;
  localparam int HOLD     = 4;
  localparam int WD_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_start = 1'b0;
  logic       tx_byte = 1'b0;
  logic       line_in;
  logic       line_out, bit_stb, busy, done;

  // Receiver model: the shared wire is low while the transmitter or the receiver pulls it.
  logic pull = 1'b0;
  int   pull_left = 0;
  int   pull_len = 1;
  assign line_in = line_out & ~pull;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_drv = 0, t_rel = 0, rel_cyc = 0;
  bit in_bit = 1'b0, rel_valid = 1'b0;
  logic exp_q[$];

  always #2.5 clk = ~clk;

  nhtx_top #(.HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_start(tx_start),
    .tx_byte(tx_byte), .line_in(line_in), .line_out(line_out),
    .bit_stb(bit_stb), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: pops the scoreboard on every drive strobe, times every return strobe.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
        finish_run();
      end
      if (pull) begin
        if (pull_left <= 1) begin
          pull = 1'b0; rel_cyc = cyc; rel_valid = 1'b1;
        end else pull_left--;
      end
      if (bit_stb) begin
        if (!in_bit) begin
          in_bit = 1'b1; t_drv = cyc;
          if (exp_q.size() == 0) chk(0, "R2 unexpected bit", line_out, -1);
          else begin
            logic e;
            e = exp_q.pop_front();
            chk(line_out == e, "R4 R6 bit value", line_out, e);
          end
          if (rel_valid) begin
            chk(cyc - rel_cyc == 3, "R5 release-to-drive latency", cyc - rel_cyc, 3);
            rel_valid = 1'b0;
          end
        end else begin
          in_bit = 1'b0; t_rel = cyc;
          chk(line_out == 1'b1, "R7 wire returned high", line_out, 1);
          chk(cyc - t_drv == HOLD, "R8 strobe spacing", cyc - t_drv, HOLD);
          if (exp_q.size() != 0) begin
            pull = 1'b1; pull_left = pull_len;
          end
        end
      end else if (in_bit) begin
        if (exp_q.size() == 0 && !busy) chk(0, "R10 busy dropped mid-bit", busy, 1);
      end
      if (done) begin
        chk(cyc - t_rel == 1, "R10 done after last return", cyc - t_rel, 1);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
        chk(exp_q.size() == 0, "R3 R9 bit count", exp_q.size(), 0);
      end
    end
  end

  // Driver: pushes the expected bits, then starts the transfer.
  task automatic send(input logic [7:0] d, input bit wide, input int k,
                      input int pre, input bit spam);
    pull_len = k;
    if (wide) for (int i = 7; i >= 0; i--) exp_q.push_back(d[i]);
    else      for (int i = 3; i >= 0; i--) exp_q.push_back(d[i]);
    if (pre > 0) begin
      @(posedge clk); #1;
      pull = 1'b1; pull_left = pre;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    tx_data = d; tx_byte = wide; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    if (spam) begin
      repeat (6) @(negedge clk);
      chk(busy == 1'b1, "R2 still busy at second start", busy, 1);
      tx_data = ~d; tx_byte = ~wide; tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    repeat (12) @(negedge clk);
    chk(busy == 1'b0, "R2 no further transfer", busy, 0);
    chk(line_out == 1'b1, "R7 wire high after end", line_out, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(line_out == 1'b1, "R11 reset line_out", line_out, 1);
    chk(bit_stb == 1'b0, "R11 reset bit_stb", bit_stb, 0);
    chk(busy == 1'b0, "R11 reset busy", busy, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(8'h0A, 1'b0, 2, 0, 1'b0);  // R3 R4: narrow, alternating bits
    send(8'hF5, 1'b0, 5, 0, 1'b0);  // R3: upper nibble must be dropped
    send(8'h3C, 1'b1, 1, 0, 1'b0);  // R9: wide, upper nibble first
    send(8'hA6, 1'b1, 3, 0, 1'b1);  // R2: start during a wide transfer
    send(8'h96, 1'b1, 2, 8, 1'b0);  // R5: wire held low before start
    send(8'h00, 1'b0, 4, 8, 1'b0);  // R6: all zero bits
    send(8'hFF, 1'b1, 1, 0, 1'b0);  // R6: all one bits
    send(8'h81, 1'b0, 3, 0, 1'b1);  // R2: start during a narrow transfer

    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule